// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block controls start-up for one direction of a point-to-point serial link. It holds the transmitter's output driver off until the supply is good and the transmit PLL reports lock. Once the driver is on, it chooses between training (sync) patterns and payload on each cycle. On the receive side it follows the receive PLL lock. From that it produces a data-valid flag, an active-low lock output and a sticky loss-of-signal status bit. A timeout alarm flags a receiver that fails to lock within a bounded time while the peer is training it.

The analog PLLs, clock recovery and the serializer datapath are outside the block, and each is represented only by a lock flag. The lock flags, power-good, the external sync pin and the remote loss-of-signal flag all arrive asynchronously. Each is resynchronised before the state logic uses it. The sync register bit and the two mode selects are treated as synchronous configuration. A small read port returns the status bits.

Top module: `link_init_seq`

## Requirements
- R1: While reset is applied or power-good is low, tx_oe=0, sync_sel=0, rx_valid=0, lock_n=1 and los_flag=1.
- R2: tx_oe is 1 only while power-good and transmit PLL lock are both high. It returns to 0 when either drops.
- R3: With auto_sync_en=0, sync_sel = tx_oe AND (sync_reg OR sync_pin). When sync_sel=0, payload is sent.
- R4: With auto_sync_en=1, remote_los takes the place of sync_pin in R3, and sync_pin has no effect on sync_sel.
- R5: rx_valid is 1 exactly while power-good and receive PLL lock are both high.
- R6: lock_n is the inverse of rx_valid in every cycle, so both outputs change on the same clock edge.
- R7: los_flag comes out of reset as 1. It clears on the edge where rx_valid rises and is set again on the edge where rx_valid falls.
- R8: With peer_sync_mode=1, lock_alarm rises after LOCK_TIMEOUT_CYC consecutive cycles in which power-good is high and receive lock is low. The alarm falls on the edge where lock is reached, or when the waiting condition ends. With peer_sync_mode=0 the alarm stays 0.
- R9: At rd_addr=0, rd_data bit 0 is los_flag, bit 1 is lock_alarm, and all other bits are 0. Every other address reads 0.
- R10: A change on an asynchronous input (pwr_good, tx_pll_lock, rx_pll_lock, sync_pin, remote_los) reaches the outputs on the third rising edge after it. A change on sync_reg, auto_sync_en or peer_sync_mode reaches the outputs on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Supply-good indication (async) |
| tx_pll_lock | input | 1 | Transmit PLL locked (async) |
| rx_pll_lock | input | 1 | Receive PLL locked to the incoming stream (async) |
| sync_pin | input | 1 | External training request (async) |
| sync_reg | input | 1 | Register training request (sync) |
| remote_los | input | 1 | Peer reports loss of signal (async) |
| auto_sync_en | input | 1 | 1: remote_los replaces sync_pin as the request source |
| peer_sync_mode | input | 1 | 1: peer trains with sync patterns, so the lock timeout applies |
| rd_addr | input | ADDR_W | Status read address |
| tx_oe | output | 1 | Transmit driver enable (0 = high impedance) |
| sync_sel | output | 1 | 1 = send sync pattern, 0 = send payload |
| rx_valid | output | 1 | Receive data valid |
| lock_n | output | 1 | Active-low receive lock |
| los_flag | output | 1 | Sticky local loss-of-signal |
| lock_alarm | output | 1 | Receive lock timeout alarm |
| rd_data | output | DATA_W | Status read data (combinational from rd_addr) |

## Verification
A change on an asynchronous input shows at the outputs on the third rising edge after it: two synchroniser stages and then the state register. Synchronous configuration inputs act on the first edge. The read port is combinational within the cycle. The bench model reproduces these delays with a two-entry queue of sampled inputs and compares every output at the falling edge. It also pins the three-edge delay with a directed check that sees no change after two edges and the change after the third. The timeout is checked after a wait longer than LOCK_TIMEOUT_CYC, and again with training off, where the alarm must stay 0.

// File: rtl/lis_pkg.sv
package lis_pkg;
  typedef enum logic {TX_OFF = 1'b0, TX_ON = 1'b1} tx_state_e;
  typedef enum logic {RX_HUNT = 1'b0, RX_LOCKED = 1'b1} rx_state_e;
  localparam int LOS_BIT = 0;
  localparam int ALM_BIT = 1;
  localparam int N_ASYNC = 5;
endpackage

// File: rtl/lis_sync.sv
module lis_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lis_tx_ctl.sv
module lis_tx_ctl
  import lis_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic txl_s,
  input  logic pin_s,
  input  logic rlos_s,
  input  logic sync_reg,
  input  logic auto_sync_en,
  output logic tx_oe,
  output logic sync_sel
);
  tx_state_e st_q, st_d;
  logic      sel_q, sel_d;
  logic      req;
  logic      upd_en;

  always_comb begin
    req    = sync_reg | (auto_sync_en ? rlos_s : pin_s);
    st_d   = (pg_s && txl_s) ? TX_ON : TX_OFF;
    sel_d  = (st_d == TX_ON) && req;
    upd_en = (st_d != st_q) || (sel_d != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_OFF;
      sel_q <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  assign tx_oe    = (st_q == TX_ON);
  assign sync_sel = sel_q;
endmodule

// File: rtl/lis_rx_ctl.sv
module lis_rx_ctl
  import lis_pkg::*;
#(
  parameter int LOCK_TIMEOUT_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s,
  input  logic rxl_s,
  input  logic peer_sync_mode,
  output logic rx_valid,
  output logic lock_n,
  output logic los_flag,
  output logic lock_alarm
);
  rx_state_e st_q, st_d;
  logic      los_q, los_d;
  logic      wait_cond;

  always_comb begin
    st_d = (pg_s && rxl_s) ? RX_LOCKED : RX_HUNT;
    if (st_d == RX_LOCKED)
      los_d = 1'b0;
    else if (st_q == RX_LOCKED || !pg_s)
      los_d = 1'b1;
    else
      los_d = los_q;
    wait_cond = pg_s && !rxl_s && peer_sync_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_HUNT;
      los_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      los_q <= los_d;
    end
  end

  generate
    if (LOCK_TIMEOUT_CYC > 0) begin : g_timeout
      localparam int CNT_W = $clog2(LOCK_TIMEOUT_CYC + 1);
      localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_TIMEOUT_CYC);
      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = !wait_cond || (cnt_q != CNT_MAX);
        cnt_d  = wait_cond ? cnt_q + 1'b1 : '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign lock_alarm = (cnt_q == CNT_MAX);
    end else begin : g_no_timeout
      assign lock_alarm = 1'b0;
    end
  endgenerate

  assign rx_valid = (st_q == RX_LOCKED);
  assign lock_n   = (st_q != RX_LOCKED);
  assign los_flag = los_q;
endmodule

// File: rtl/link_init_seq.sv
module link_init_seq
  import lis_pkg::*;
#(
  parameter int LOCK_TIMEOUT_CYC = 1250,
  parameter int SYNC_STAGES      = 2,
  parameter int ADDR_W           = 2,
  parameter int DATA_W           = 8,
  parameter int STATUS_ADDR      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              tx_pll_lock,
  input  logic              rx_pll_lock,
  input  logic              sync_pin,
  input  logic              sync_reg,
  input  logic              remote_los,
  input  logic              auto_sync_en,
  input  logic              peer_sync_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              tx_oe,
  output logic              sync_sel,
  output logic              rx_valid,
  output logic              lock_n,
  output logic              los_flag,
  output logic              lock_alarm,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_STAGES-1];

  logic [N_ASYNC-1:0] async_in, async_s;
  logic pg_s, txl_s, rxl_s, pin_s, rlos_s;

  assign async_in = {pwr_good, tx_pll_lock, rx_pll_lock, sync_pin, remote_los};

  lis_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (async_in),
    .q     (async_s)
  );

  assign {pg_s, txl_s, rxl_s, pin_s, rlos_s} = async_s;

  lis_tx_ctl u_tx (
    .clk          (clk),
    .rst_n        (srst_n),
    .pg_s         (pg_s),
    .txl_s        (txl_s),
    .pin_s        (pin_s),
    .rlos_s       (rlos_s),
    .sync_reg     (sync_reg),
    .auto_sync_en (auto_sync_en),
    .tx_oe        (tx_oe),
    .sync_sel     (sync_sel)
  );

  lis_rx_ctl #(.LOCK_TIMEOUT_CYC(LOCK_TIMEOUT_CYC)) u_rx (
    .clk            (clk),
    .rst_n          (srst_n),
    .pg_s           (pg_s),
    .rxl_s          (rxl_s),
    .peer_sync_mode (peer_sync_mode),
    .rx_valid       (rx_valid),
    .lock_n         (lock_n),
    .los_flag       (los_flag),
    .lock_alarm     (lock_alarm)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_A) begin
      rd_data[LOS_BIT] = los_flag;
      rd_data[ALM_BIT] = lock_alarm;
    end
  end
endmodule

// File: rtl/link_init_seq_chk.sv
module link_init_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pg_s,
  input logic txl_s,
  input logic rxl_s,
  input logic tx_oe,
  input logic sync_sel,
  input logic rx_valid,
  input logic los_flag,
  input logic lock_alarm
);
  AST_TXOE_OFF_NO_PG: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> !tx_oe); // R1
  AST_TXOE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> $past(txl_s)); // R2
  AST_SYNC_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel |-> tx_oe); // R3
  AST_VALID_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_s && rxl_s) |=> rx_valid); // R5
  AST_LOS_CLEAR_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !los_flag); // R7
  AST_LOS_SET_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rxl_s) |=> (los_flag && !rx_valid)); // R7
  AST_ALARM_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_alarm |-> !rx_valid); // R8
endmodule

bind link_init_seq link_init_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pg_s       (pg_s),
  .txl_s      (txl_s),
  .rxl_s      (rxl_s),
  .tx_oe      (tx_oe),
  .sync_sel   (sync_sel),
  .rx_valid   (rx_valid),
  .los_flag   (los_flag),
  .lock_alarm (lock_alarm)
);

// File: tb/link_init_seq_bench.sv
`timescale 1ns/1ps
module link_init_seq_bench;
  localparam int LIM = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 0, tx_pll_lock = 0, rx_pll_lock = 0, sync_pin = 0;
  logic sync_reg = 0, remote_los = 0, auto_sync_en = 0, peer_sync_mode = 0;
  logic [1:0] rd_addr = 2'd0;
  logic tx_oe, sync_sel, rx_valid, lock_n, los_flag, lock_alarm;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  link_init_seq u_link_init_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tx_pll_lock(tx_pll_lock),
    .rx_pll_lock(rx_pll_lock), .sync_pin(sync_pin), .sync_reg(sync_reg),
    .remote_los(remote_los), .auto_sync_en(auto_sync_en),
    .peer_sync_mode(peer_sync_mode), .rd_addr(rd_addr), .tx_oe(tx_oe),
    .sync_sel(sync_sel), .rx_valid(rx_valid), .lock_n(lock_n),
    .los_flag(los_flag), .lock_alarm(lock_alarm), .rd_data(rd_data)
  );

  // behavioural reference: queue of sampled async inputs, 2 deep
  bit [4:0] q_in [$];
  int  m_rst;
  bit  m_tx, m_sel, m_lock, m_los;
  int  m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_in.delete(); q_in.push_back(5'd0); q_in.push_back(5'd0);
      m_rst = 0; m_tx = 0; m_sel = 0; m_lock = 0; m_los = 1; m_cnt = 0;
    end else if (m_rst < 2) begin
      m_rst++;
    end else begin
      bit [4:0] s;
      bit pg, tl, rl, pn, rs, req, was;
      s  = q_in.pop_front();
      pg = s[4]; tl = s[3]; rl = s[2]; pn = s[1]; rs = s[0];
      req   = sync_reg || (auto_sync_en ? rs : pn);
      m_tx  = pg && tl;
      m_sel = m_tx && req;
      was   = m_lock;
      m_lock = pg && rl;
      if (m_lock) m_los = 0;
      else if (was || !pg) m_los = 1;
      if (pg && !rl && peer_sync_mode) begin
        if (m_cnt < LIM) m_cnt++;
      end else m_cnt = 0;
      q_in.push_back({pwr_good, tx_pll_lock, rx_pll_lock, sync_pin, remote_los});
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit alm;
      int exp_rd;
      alm = (m_cnt == LIM);
      exp_rd = (rd_addr == 2'd0) ? {alm, m_los} : 0;
      chk("R2", "tx_oe", tx_oe, m_tx);
      chk("R3", "sync_sel", sync_sel, m_sel);
      chk("R5", "rx_valid", rx_valid, m_lock);
      chk("R6", "lock_n", lock_n, !m_lock);
      chk("R7", "los_flag", los_flag, m_los);
      chk("R8", "lock_alarm", lock_alarm, alm);
      chk("R9", "rd_data", rd_data, exp_rd);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(5);
    // R1: state after reset with power-good low
    chk("R1", "tx_oe", tx_oe, 0);  chk("R1", "lock_n", lock_n, 1);
    chk("R1", "los_flag", los_flag, 1); chk("R1", "rx_valid", rx_valid, 0);
    tx_pll_lock = 1; step(6);
    chk("R1", "tx_oe pg low", tx_oe, 0);
    tx_pll_lock = 0; pwr_good = 1; step(6);
    chk("R2", "tx_oe no lock", tx_oe, 0);
    // R10: async latency is three edges
    tx_pll_lock = 1; step(2);
    chk("R10", "tx_oe after 2 edges", tx_oe, 0);
    step(1);
    chk("R10", "tx_oe after 3 edges", tx_oe, 1);
    sync_pin = 1; step(6); chk("R3", "sync via pin", sync_sel, 1);
    sync_pin = 0; step(6); chk("R3", "payload", sync_sel, 0);
    sync_reg = 1; step(1); chk("R10", "sync_reg one edge", sync_sel, 1);
    sync_reg = 0; step(4);
    auto_sync_en = 1; sync_pin = 1; step(6);
    chk("R4", "pin ignored in auto", sync_sel, 0);
    remote_los = 1; step(6); chk("R4", "remote los request", sync_sel, 1);
    remote_los = 0; sync_pin = 0; auto_sync_en = 0; step(6);
    // R8: timeout with training peer
    peer_sync_mode = 1; step(LIM + 10);
    chk("R8", "alarm raised", lock_alarm, 1);
    chk("R9", "status read", rd_data, 3);
    rd_addr = 2'd2; step(1); chk("R9", "other address", rd_data, 0);
    rd_addr = 2'd0;
    rx_pll_lock = 1; step(6);
    chk("R5", "rx_valid", rx_valid, 1); chk("R8", "alarm cleared", lock_alarm, 0);
    chk("R7", "los cleared", los_flag, 0); chk("R6", "lock_n", lock_n, 0);
    rx_pll_lock = 0; step(6);
    chk("R7", "los set on loss", los_flag, 1); chk("R5", "rx_valid lost", rx_valid, 0);
    peer_sync_mode = 0; step(LIM + 10);
    chk("R8", "no alarm random data", lock_alarm, 0);
    rx_pll_lock = 1; step(6);
    sync_reg = 1; tx_pll_lock = 0; step(6);
    chk("R2", "tx off on lock loss", tx_oe, 0);
    chk("R3", "no sync while off", sync_sel, 0);
    tx_pll_lock = 1; step(6); chk("R2", "tx back", tx_oe, 1);
    pwr_good = 0; step(6);
    chk("R1", "tx off pg low", tx_oe, 0); chk("R1", "lock_n pg low", lock_n, 1);
    chk("R1", "los pg low", los_flag, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule